// File: doc/BRIEF.md
# Unaligned Vector Load Aligner

This block carries out a vector register load from a byte address that may sit at any byte position. A request gives the address, a two-bit form code and a four-bit register-specifier field. The block then issues one or two naturally aligned line reads to a simple memory port. It concatenates the returned lines, shifts out the operand bytes and returns a full-width destination image with a write enable.

There are three load forms, and each has its own rule for the upper half of the destination. The short legacy form merges with the old register value that arrives with the request. The short extended form clears the upper half. The wide form writes every bit.

An extended-form request whose specifier field is not all ones ends with an undefined-opcode fault. The reserved form code ends the same way. In both cases there is no memory traffic and no register write. Requests use a valid/ready handshake with one request in flight at a time. Memory latency may vary.

Top module: `vload_align`

## Requirements
- R1: The operand holds 16 bytes for both short forms and 32 bytes for the wide form, taken from consecutive addresses starting at `req_addr`. Byte order is little-endian: the byte at `req_addr` lands in `done_data[7:0]`.
- R2: No start address causes a fault for forms 00, 01 or 10 with a valid specifier. Every such request ends with `done_wen` high and `done_fault` low.
- R3: A memory read addresses a whole line, and `mem_req_line` = address >> 5. If the operand lies within one 32-byte line, exactly one read is issued. If it crosses into the next line, exactly two reads are issued: first the line holding `req_addr`, then the line after it.
- R4: Form code 00 (legacy short) writes bits 127:0 with the operand and returns bits 255:128 equal to `req_old[255:128]`.
- R5: Form code 01 (extended short) writes bits 127:0 with the operand and returns bits 255:128 as zero.
- R6: Form code 10 (extended wide) returns all 256 bits from the operand.
- R7: For form codes 01 and 10, a specifier other than 4'b1111 produces the following, in the cycle after acceptance: `done` high, `done_fault` high and `done_wen` low. No memory read is issued for that request.
- R8: For form code 00, the specifier field is ignored. Any value loads normally with no fault.
- R9: Form code 11 is reserved. It faults exactly as in R7, whatever the specifier.
- R10: `req_ready` is high only while no request is in flight. `done` is a single-cycle pulse for each accepted request. A pending `mem_req_valid` holds its line address stable until `mem_req_ready`. A new request may be accepted in the same cycle that `done` reports the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Byte start address of the operand |
| req_form | input | 2 | Form code: 00 legacy short, 01 extended short, 10 extended wide, 11 reserved |
| req_spec | input | 4 | Register-specifier field, must be 4'b1111 for extended forms |
| req_old | input | LINE_BYTES*8 | Current destination register value |
| mem_req_valid | output | 1 | Line read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_line | output | ADDR_W-5 | Aligned line address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | LINE_BYTES*8 | Read line data, lowest address in bits 7:0 |
| done | output | 1 | Result pulse |
| done_wen | output | 1 | Destination write enable |
| done_fault | output | 1 | Undefined-opcode fault |
| done_data | output | LINE_BYTES*8 | Destination image to write |

## Verification
The completion pulse of one load and the acceptance of the next request can occur on the same clock edge. The bench provokes this by holding the next request valid while the current one is still in flight. That next request is a faulting one, so its own completion must appear in the very next cycle. The bench checks that the first result is correct and that `req_ready` is high in its `done` cycle. It then checks that the fault result follows directly, with no memory read and no write enable.

// File: rtl/vload_pkg.sv
package vload_pkg;
  typedef enum logic [1:0] {
    FORM_LEG  = 2'b00,
    FORM_V128 = 2'b01,
    FORM_V256 = 2'b10,
    FORM_RSV  = 2'b11
  } form_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ0,
    S_RSP0,
    S_REQ1,
    S_RSP1
  } st_e;

  localparam logic [3:0] SPEC_OK = 4'b1111;
endpackage

// File: rtl/vload_plan.sv
module vload_plan import vload_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  form_e             form,
  input  logic [3:0]        spec,
  output logic [LA_W-1:0]   line,
  output logic [OFF_W-1:0]  off,
  output logic              two,
  output logic              fault
);
  localparam logic [OFF_W+1:0] FULL_N = (OFF_W+2)'(LINE_BYTES);
  localparam logic [OFF_W+1:0] HALF_N = (OFF_W+2)'(LINE_BYTES / 2);

  logic [OFF_W+1:0] span;

  always_comb begin
    line  = addr[ADDR_W-1:OFF_W];
    off   = addr[OFF_W-1:0];
    span  = {2'b00, off} + ((form == FORM_V256) ? FULL_N : HALF_N);
    two   = span > FULL_N;
    fault = (form == FORM_RSV) || ((form != FORM_LEG) && (spec != SPEC_OK));
  end
endmodule

// File: rtl/vload_extract.sv
module vload_extract #(
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic [LINE_W-1:0] lo,
  input  logic [LINE_W-1:0] hi,
  input  logic [OFF_W-1:0]  off,
  output logic [LINE_W-1:0] ext
);
  logic [2*LINE_W-1:0] cat;
  assign cat = {hi, lo};

  for (genvar gi = 0; gi < LINE_BYTES; gi++) begin : g_byte
    logic [OFF_W:0] idx;
    assign idx = {1'b0, off} + (OFF_W+1)'(gi);
    assign ext[gi*8 +: 8] = cat[idx*8 +: 8];
  end
endmodule

// File: rtl/vload_merge.sv
module vload_merge import vload_pkg::*; #(
  parameter int LINE_BYTES = 32,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int HALF_W    = LINE_W / 2
) (
  input  form_e             form,
  input  logic [LINE_W-1:0] ext,
  input  logic [LINE_W-1:0] old,
  output logic [LINE_W-1:0] wdata
);
  always_comb begin
    case (form)
      FORM_LEG:  wdata = {old[LINE_W-1:HALF_W], ext[HALF_W-1:0]};
      FORM_V128: wdata = {{HALF_W{1'b0}}, ext[HALF_W-1:0]};
      default:   wdata = ext;
    endcase
  end
endmodule

// File: rtl/vload_align.sv
module vload_align import vload_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_form,
  input  logic [3:0]        req_spec,
  input  logic [LINE_W-1:0] req_old,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [LA_W-1:0]   mem_req_line,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data,
  output logic              done,
  output logic              done_wen,
  output logic              done_fault,
  output logic [LINE_W-1:0] done_data
);
  st_e               state;
  logic [LA_W-1:0]   line_q;
  logic [OFF_W-1:0]  off_q;
  logic              two_q;
  form_e             form_q;
  logic [LINE_W-1:0] old_q;
  logic [LINE_W-1:0] lo_q;

  logic [LA_W-1:0]   p_line;
  logic [OFF_W-1:0]  p_off;
  logic              p_two;
  logic              p_fault;
  logic [LINE_W-1:0] ext_lo, ext_hi, ext, wdata;
  logic              last_rsp;

  vload_plan #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) plan_i (
    .addr (req_addr),
    .form (form_e'(req_form)),
    .spec (req_spec),
    .line (p_line),
    .off  (p_off),
    .two  (p_two),
    .fault(p_fault)
  );

  // Single-line loads place the only line low; straddles put the newest line high.
  assign ext_lo = two_q ? lo_q : mem_rsp_data;
  assign ext_hi = two_q ? mem_rsp_data : '0;

  vload_extract #(.LINE_BYTES(LINE_BYTES)) extract_i (
    .lo (ext_lo),
    .hi (ext_hi),
    .off(off_q),
    .ext(ext)
  );

  vload_merge #(.LINE_BYTES(LINE_BYTES)) merge_i (
    .form (form_q),
    .ext  (ext),
    .old  (old_q),
    .wdata(wdata)
  );

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_REQ0) || (state == S_REQ1);
  assign mem_req_line  = (state == S_REQ1) ? line_q + LA_W'(1) : line_q;
  assign last_rsp      = mem_rsp_valid &&
                         (((state == S_RSP0) && !two_q) || (state == S_RSP1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      line_q     <= '0;
      off_q      <= '0;
      two_q      <= 1'b0;
      form_q     <= FORM_LEG;
      old_q      <= '0;
      lo_q       <= '0;
      done       <= 1'b0;
      done_wen   <= 1'b0;
      done_fault <= 1'b0;
      done_data  <= '0;
    end else begin
      done       <= 1'b0;
      done_wen   <= 1'b0;
      done_fault <= 1'b0;
      if (last_rsp) begin
        done      <= 1'b1;
        done_wen  <= 1'b1;
        done_data <= wdata;
      end
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            line_q <= p_line;
            off_q  <= p_off;
            two_q  <= p_two;
            form_q <= form_e'(req_form);
            old_q  <= req_old;
            if (p_fault) begin
              done       <= 1'b1;
              done_fault <= 1'b1;
              done_data  <= req_old;
            end else begin
              state <= S_REQ0;
            end
          end
        end
        S_REQ0: if (mem_req_ready) state <= S_RSP0;
        S_RSP0: begin
          if (mem_rsp_valid) begin
            if (two_q) begin
              lo_q  <= mem_rsp_data;
              state <= S_REQ1;
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_REQ1: if (mem_req_ready) state <= S_RSP1;
        S_RSP1: if (mem_rsp_valid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vload_align_chk.sv
module vload_align_chk import vload_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LA_W      = ADDR_W - OFF_W,
  localparam int HALF_W    = LINE_BYTES * 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [OFF_W-1:0]  req_off,
  input logic [1:0]        req_form,
  input logic [3:0]        req_spec,
  input logic [HALF_W-1:0] req_old_hi,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [LA_W-1:0]   mem_req_line,
  input logic              done,
  input logic              done_wen,
  input logic              done_fault,
  input logic [HALF_W-1:0] done_hi
);
  logic              acc, bad_req, two_req;
  logic [1:0]        form_t;
  logic [HALF_W-1:0] old_t;
  logic              two_t;
  logic [1:0]        hs_cnt;
  logic [LA_W-1:0]   first_line;

  assign acc     = req_valid && req_ready;
  assign bad_req = (req_form == 2'b11) || ((req_form != 2'b00) && (req_spec != 4'b1111));
  assign two_req = (int'(req_off) + ((req_form == 2'b10) ? LINE_BYTES : LINE_BYTES / 2)) > LINE_BYTES;

  always_ff @(posedge clk) begin
    if (rst) begin
      form_t     <= 2'b00;
      old_t      <= '0;
      two_t      <= 1'b0;
      hs_cnt     <= '0;
      first_line <= '0;
    end else if (acc) begin
      form_t <= req_form;
      old_t  <= req_old_hi;
      two_t  <= two_req;
      hs_cnt <= '0;
    end else if (mem_req_valid && mem_req_ready) begin
      if (hs_cnt == 2'd0) first_line <= mem_req_line;
      if (hs_cnt != 2'd3) hs_cnt <= hs_cnt + 2'd1;
    end
  end

  a_r7_fault_next: assert property (@(posedge clk) disable iff (rst)
    acc && bad_req |=> done && done_fault && !done_wen);
  a_r7_no_read: assert property (@(posedge clk) disable iff (rst)
    acc && bad_req |=> !mem_req_valid);
  a_r8_legacy_ok: assert property (@(posedge clk) disable iff (rst)
    done && form_t == 2'b00 |-> !done_fault && done_wen);
  a_r4_upper_keep: assert property (@(posedge clk) disable iff (rst)
    done && done_wen && form_t == 2'b00 |-> done_hi == old_t);
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    done && done_wen && form_t == 2'b01 |-> done_hi == '0);
  a_r3_read_count: assert property (@(posedge clk) disable iff (rst)
    done && done_wen |-> hs_cnt == (two_t ? 2'd2 : 2'd1));
  a_r3_next_line: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && hs_cnt == 2'd1 |-> mem_req_line == first_line + LA_W'(1));
  a_r10_hold_req: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_line));
  a_r10_one_flight: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);
endmodule

bind vload_align vload_align_chk #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_off      (req_addr[$clog2(LINE_BYTES)-1:0]),
  .req_form     (req_form),
  .req_spec     (req_spec),
  .req_old_hi   (req_old[LINE_BYTES*8-1:LINE_BYTES*4]),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_line (mem_req_line),
  .done         (done),
  .done_wen     (done_wen),
  .done_fault   (done_fault),
  .done_hi      (done_data[LINE_BYTES*8-1:LINE_BYTES*4])
);

// File: tb/vload_align_tb.sv
`timescale 1ns/1ps
module vload_align_tb_top;
  localparam int AW = 32;
  localparam int LW = 256;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_form;
  logic [3:0]    req_spec;
  logic [LW-1:0] req_old;
  logic          mem_req_valid;
  logic          mem_req_ready;
  logic [AW-6:0] mem_req_line;
  logic          mem_rsp_valid;
  logic [LW-1:0] mem_rsp_data;
  logic          done, done_wen, done_fault;
  logic [LW-1:0] done_data;

  int checks = 0;
  int errors = 0;
  int nrd;
  int rd_line [2];

  always #4 clk = ~clk;

  vload_align dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_form(req_form), .req_spec(req_spec), .req_old(req_old),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_line(mem_req_line), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_wen(done_wen),
    .done_fault(done_fault), .done_data(done_data)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  form;
    logic [3:0]  spec;
    logic        flt;
    logic [1:0]  reads;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h00, 2'd0, 4'h0, 1'b0, 2'd1},
    '{32'h05, 2'd0, 4'hF, 1'b0, 2'd1},
    '{32'h10, 2'd1, 4'hF, 1'b0, 2'd1},
    '{32'h11, 2'd1, 4'hF, 1'b0, 2'd2},
    '{32'h1F, 2'd0, 4'h3, 1'b0, 2'd2},
    '{32'h40, 2'd2, 4'hF, 1'b0, 2'd1},
    '{32'h41, 2'd2, 4'hF, 1'b0, 2'd2},
    '{32'h7F, 2'd2, 4'hF, 1'b0, 2'd2},
    '{32'h23, 2'd1, 4'hE, 1'b1, 2'd0},
    '{32'h00, 2'd2, 4'h0, 1'b1, 2'd0},
    '{32'h08, 2'd3, 4'hF, 1'b1, 2'd0},
    '{32'h3C, 2'd0, 4'hF, 1'b0, 2'd2}
  };

  function automatic logic [7:0] mb(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [LW-1:0] line_val(int l);
    logic [LW-1:0] v;
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = mb(l * 32 + i);
    return v;
  endfunction

  function automatic logic [LW-1:0] exp_data(int a, logic [1:0] f, logic [LW-1:0] old);
    logic [LW-1:0] e;
    for (int i = 0; i < 32; i++) e[i*8 +: 8] = mb(a + i);
    case (f)
      2'd0:    return {old[255:128], e[127:0]};
      2'd1:    return {128'b0, e[127:0]};
      default: return e;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: stalls on ready, latency of 0..2 extra cycles.
  initial begin
    int tick = 0;
    int pline = 0;
    int lat = 0;
    bit pend = 0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    nrd = 0;
    forever begin
      @(negedge clk);
      tick++;
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = line_val(pline);
          pend = 0;
        end else begin
          lat--;
        end
      end
      mem_req_ready = !pend && (tick % 4 != 1);
      if (mem_req_valid && mem_req_ready) begin
        pend  = 1;
        pline = int'(mem_req_line);
        lat   = tick % 3;
        if (nrd < 2) rd_line[nrd] = pline;
        nrd++;
      end
    end
  end

  task automatic drive(input logic [31:0] a, input logic [1:0] f, input logic [3:0] s, input logic [LW-1:0] old);
    req_valid = 1'b1;
    req_addr  = a;
    req_form  = f;
    req_spec  = s;
    req_old   = old;
  endtask

  task automatic do_req(input logic [31:0] a, input logic [1:0] f, input logic [3:0] s, input logic [LW-1:0] old);
    nrd = 0;
    drive(a, f, s, old);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    int cyc;
    logic [LW-1:0] old, ev;
    rst = 1'b1;
    req_valid = 1'b0;
    req_addr = '0;
    req_form = '0;
    req_spec = '0;
    req_old = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle state after reset
    chk(req_ready == 1'b1, "R10 ready after reset", LW'(req_ready), LW'(1));
    chk(done == 1'b0, "R10 no done after reset", LW'(done), LW'(0));
    chk(mem_req_valid == 1'b0, "R10 no read after reset", LW'(mem_req_valid), LW'(0));

    for (int k = 0; k < NV; k++) begin
      old = {8{32'hC3A50000 | 32'(k)}};
      do_req(VECS[k].addr, VECS[k].form, VECS[k].spec, old);
      wait_done(cyc);
      chk(done == 1'b1, "R10 done pulse seen", LW'(done), LW'(1));
      if (VECS[k].flt) begin
        // R7 / R9: fault right after acceptance, no read, no write
        chk(done_fault == 1'b1, "R7 R9 fault flag", LW'(done_fault), LW'(1));
        chk(done_wen == 1'b0, "R7 R9 no write", LW'(done_wen), LW'(0));
        chk(cyc == 0, "R7 fault timing", LW'(cyc), LW'(0));
        chk(nrd == 0, "R7 R9 no memory read", LW'(nrd), LW'(0));
      end else begin
        ev = exp_data(int'(VECS[k].addr), VECS[k].form, old);
        chk(done_fault == 1'b0 && done_wen == 1'b1, "R2 R8 loads without fault",
            LW'({done_fault, done_wen}), LW'(2'b01));
        case (VECS[k].form)
          2'd0:    chk(done_data == ev, "R1 R4 legacy data", done_data, ev);
          2'd1:    chk(done_data == ev, "R1 R5 short data", done_data, ev);
          default: chk(done_data == ev, "R1 R6 wide data", done_data, ev);
        endcase
        chk(nrd == int'(VECS[k].reads), "R3 read count", LW'(nrd), LW'(VECS[k].reads));
        chk(rd_line[0] == int'(VECS[k].addr >> 5), "R3 first line", LW'(rd_line[0]), LW'(VECS[k].addr >> 5));
        if (nrd == 2)
          chk(rd_line[1] == rd_line[0] + 1, "R3 second line", LW'(rd_line[1]), LW'(rd_line[0] + 1));
      end
      @(negedge clk);
      chk(done == 1'b0, "R10 done single cycle", LW'(done), LW'(0));
    end

    // R10: next request accepted in the cycle that reports the previous one
    old = {4{64'h0123456789ABCDEF}};
    do_req(32'h45, 2'd2, 4'hF, old);
    drive(32'h20, 2'd1, 4'h0, ~old);
    wait_done(cyc);
    ev = exp_data(32'h45, 2'd2, old);
    chk(done_data == ev && done_wen, "R6 R10 result before overlap", done_data, ev);
    chk(req_ready == 1'b1, "R10 ready in done cycle", LW'(req_ready), LW'(1));
    @(negedge clk);
    req_valid = 1'b0;
    chk(done && done_fault && !done_wen, "R7 R10 overlapped fault result",
        LW'({done, done_fault, done_wen}), LW'(3'b110));
    chk(nrd == 2, "R7 R10 no extra read", LW'(nrd), LW'(2));

    // Reset in flight, then a fresh load
    nrd = 0;
    drive(32'h33, 2'd0, 4'h0, old);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R10 reset aborts load",
        LW'({req_ready, done}), LW'(2'b10));
    do_req(32'h2E, 2'd0, 4'h9, old);
    wait_done(cyc);
    ev = exp_data(32'h2E, 2'd0, old);
    chk(done_data == ev, "R4 R8 load after reset", done_data, ev);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule